// File: doc/BRIEF.md
# Two-Port Shared Memory with Cross-Port Mailbox Flags

This block is a clocked shared memory with two fully independent access ports, called left and right. Each port has two chip enables, a read/write control, an output enable, two byte-lane selects, an address and separate write and read data buses. Either port can read or write any word at any time.

Two words at the top of the address space act as mailboxes between the ports. When one port writes the other port's mailbox, the owner's active-low interrupt flag goes low. The flag goes high again when the owner reads its own mailbox. The mailbox contents have no fixed meaning to the block. They are stored and returned like any other word. The word width is 16 or 18 bits. Each word is split into a lower lane and an upper lane, and each lane can be written on its own.

Top module: `dpm_top`

## Requirements
- R1: A port acts only when its `ce0N` is low and its `ce1N` is high. A deselected port writes nothing, drives no read data and leaves both interrupt flags alone.
- R2: A write is requested with `weN` low. `lbN` low writes the lower lane, which is bits [7:0] when DATA_W is 16 and bits [8:0] when DATA_W is 18. `ubN` low writes the remaining upper bits. A lane whose select is high keeps its old contents.
- R3: A read is requested with `weN` high and `oeN` low. The word is returned one clock later on `rdData`. `rdLaneOe[0]` marks the lower lane as driven and `rdLaneOe[1]` marks the upper lane. A lane that is not driven reads as zero.
- R4: A word written through one port can be read back through the other port.
- R5: The right port's mailbox is word DEPTH-1 and the left port's mailbox is word DEPTH-2. A write by the left port to DEPTH-1 pulls `rIntN` low from the next cycle on. A write by the right port to DEPTH-2 pulls `lIntN` low in the same way.
- R6: A port's flag returns high in the cycle after that port reads its own mailbox. A port writing its own mailbox never lowers its own flag.
- R7: If the owner reads its mailbox in the same cycle that the opposite port writes it, the flag stays low.
- R8: If both ports write the same word in one cycle, each lane written by the left port takes the left data. Lanes written only by the right port take the right data.
- R9: A read of a word that the other port writes in the same cycle returns the old contents.
- R10: After reset both interrupt flags are high, both `rdLaneOe` outputs are zero and both `rdData` outputs are zero.
- R11: Mailbox words hold and return the data written to them like any other word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lCe0N | input | 1 | Left chip enable 0, active low |
| lCe1N | input | 1 | Left chip enable 1, active high |
| lWeN | input | 1 | Left write (low) / read (high) |
| lOeN | input | 1 | Left output enable, active low |
| lUbN | input | 1 | Left upper-lane select, active low |
| lLbN | input | 1 | Left lower-lane select, active low |
| lAddr | input | ADDR_W | Left word address |
| lWrData | input | DATA_W | Left write data |
| lRdData | output | DATA_W | Left read data, zero on undriven lanes |
| lRdLaneOe | output | 2 | Left driven lanes (bit 0 lower, bit 1 upper) |
| lIntN | output | 1 | Left mailbox flag, active low |
| rCe0N | input | 1 | Right chip enable 0, active low |
| rCe1N | input | 1 | Right chip enable 1, active high |
| rWeN | input | 1 | Right write (low) / read (high) |
| rOeN | input | 1 | Right output enable, active low |
| rUbN | input | 1 | Right upper-lane select, active low |
| rLbN | input | 1 | Right lower-lane select, active low |
| rAddr | input | ADDR_W | Right word address |
| rWrData | input | DATA_W | Right write data |
| rRdData | output | DATA_W | Right read data, zero on undriven lanes |
| rRdLaneOe | output | 2 | Right driven lanes (bit 0 lower, bit 1 upper) |
| rIntN | output | 1 | Right mailbox flag, active low |

## Verification
The bench targets four corner cases. The first is a read of a mailbox in the same cycle that the other port writes it. A design that lets the clear win would drop the new message, and one that forwards write data would return the new word instead of the old one. The second is the same word written by both ports at once, with a partial lane mask on the left. A priority error shows up as right-port data in a lane the left port wrote, or as a lost right lane. The bench also writes a port's own mailbox, which must not raise that port's flag, and it drives each chip enable to its inactive level on its own. A wrong select decode would corrupt memory or drive read data.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  // Per-port lane strobes: index 0 is the lower lane, index 1 the upper lane.
  typedef struct packed {
    logic [1:0] wr;
    logic [1:0] rd;
  } laneStb_t;
endpackage

// File: rtl/dpm_ctrl.sv
module dpm_ctrl
  import dpm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lCe0N,
  input  logic              lCe1N,
  input  logic              lWeN,
  input  logic              lOeN,
  input  logic              lUbN,
  input  logic              lLbN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              rCe0N,
  input  logic              rCe1N,
  input  logic              rWeN,
  input  logic              rOeN,
  input  logic              rUbN,
  input  logic              rLbN,
  input  logic [ADDR_W-1:0] rAddr,
  output laneStb_t          lStb,
  output laneStb_t          rStb,
  output logic              lIntN,
  output logic              rIntN
);
  localparam logic [ADDR_W-1:0] R_BOX = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] L_BOX = R_BOX - 1'b1;

  logic lSel, rSel;
  logic lSet, lClr, rSet, rClr;

  assign lSel = !lCe0N && lCe1N;
  assign rSel = !rCe0N && rCe1N;

  always_comb begin
    lStb.wr = (lSel && !lWeN) ? {!lUbN, !lLbN} : 2'b00;
    lStb.rd = (lSel && lWeN && !lOeN) ? {!lUbN, !lLbN} : 2'b00;
    rStb.wr = (rSel && !rWeN) ? {!rUbN, !rLbN} : 2'b00;
    rStb.rd = (rSel && rWeN && !rOeN) ? {!rUbN, !rLbN} : 2'b00;
  end

  assign lSet = (|rStb.wr) && (rAddr == L_BOX);
  assign lClr = (|lStb.rd) && (lAddr == L_BOX);
  assign rSet = (|lStb.wr) && (lAddr == R_BOX);
  assign rClr = (|rStb.rd) && (rAddr == R_BOX);

  // Set has priority over clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lIntN <= 1'b1;
      rIntN <= 1'b1;
    end else begin
      if (lSet)      lIntN <= 1'b0;
      else if (lClr) lIntN <= 1'b1;
      if (rSet)      rIntN <= 1'b0;
      else if (rClr) rIntN <= 1'b1;
    end
  end

  p_reset_flags_r10: assert property (@(posedge clk) !rstN |=> (lIntN && rIntN));
  p_deselect_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (lCe0N || !lCe1N) |-> (lStb == '0));
  p_left_raise_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((|rStb.wr) && rAddr == L_BOX) |=> !lIntN);
  p_right_raise_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((|lStb.wr) && lAddr == R_BOX) |=> !rIntN);
  p_left_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((|lStb.rd) && lAddr == L_BOX && !((|rStb.wr) && rAddr == L_BOX)) |=> lIntN);
  p_left_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (lIntN && !((|rStb.wr) && rAddr == L_BOX)) |=> lIntN);
  p_set_beats_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((|lStb.rd) && lAddr == L_BOX && (|rStb.wr) && rAddr == L_BOX) |=> !lIntN);
endmodule

// File: rtl/dpm_datapath.sv
module dpm_datapath
  import dpm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  laneStb_t          lStb,
  input  laneStb_t          rStb,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] lWrData,
  input  logic [DATA_W-1:0] rWrData,
  output logic [DATA_W-1:0] lRdData,
  output logic [DATA_W-1:0] rRdData,
  output logic [1:0]        lRdLaneOe,
  output logic [1:0]        rRdLaneOe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LO_W  = (DATA_W == 18) ? 9 : 8;
  localparam int HI_W  = DATA_W - LO_W;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lRdLaneOe <= 2'b00;
      rRdLaneOe <= 2'b00;
    end else begin
      lRdLaneOe <= lStb.rd;
      rRdLaneOe <= rStb.rd;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : gLane
    localparam int LW = (g == 0) ? LO_W : HI_W;
    localparam int LB = (g == 0) ? 0 : LO_W;

    logic [LW-1:0] store [DEPTH];
    logic [LW-1:0] lRdQ, rRdQ;

    // Right first, left last: on a shared address the left write sticks.
    always_ff @(posedge clk) begin
      if (rStb.wr[g]) store[rAddr] <= rWrData[LB+:LW];
      if (lStb.wr[g]) store[lAddr] <= lWrData[LB+:LW];
    end

    // Read sees the contents before this cycle's writes.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lRdQ <= '0;
        rRdQ <= '0;
      end else begin
        if (lStb.rd[g]) lRdQ <= store[lAddr];
        if (rStb.rd[g]) rRdQ <= store[rAddr];
      end
    end

    assign lRdData[LB+:LW] = lRdLaneOe[g] ? lRdQ : '0;
    assign rRdData[LB+:LW] = rRdLaneOe[g] ? rRdQ : '0;

    p_left_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
      (lStb.wr[g] && rStb.wr[g] && lAddr == rAddr)
      |=> (store[$past(lAddr)] == $past(lWrData[LB+:LW])));
    p_undriven_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
      !lStb.rd[g] |=> (lRdData[LB+:LW] == '0));
  end

  p_reset_read_r10: assert property (@(posedge clk) !rstN |=> (lRdLaneOe == 2'b00 && rRdLaneOe == 2'b00));
endmodule

// File: rtl/dpm_top.sv
module dpm_top
  import dpm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lCe0N,
  input  logic              lCe1N,
  input  logic              lWeN,
  input  logic              lOeN,
  input  logic              lUbN,
  input  logic              lLbN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWrData,
  output logic [DATA_W-1:0] lRdData,
  output logic [1:0]        lRdLaneOe,
  output logic              lIntN,
  input  logic              rCe0N,
  input  logic              rCe1N,
  input  logic              rWeN,
  input  logic              rOeN,
  input  logic              rUbN,
  input  logic              rLbN,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWrData,
  output logic [DATA_W-1:0] rRdData,
  output logic [1:0]        rRdLaneOe,
  output logic              rIntN
);
  laneStb_t lStb, rStb;

  dpm_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .lCe0N(lCe0N), .lCe1N(lCe1N), .lWeN(lWeN), .lOeN(lOeN),
    .lUbN(lUbN), .lLbN(lLbN), .lAddr(lAddr),
    .rCe0N(rCe0N), .rCe1N(rCe1N), .rWeN(rWeN), .rOeN(rOeN),
    .rUbN(rUbN), .rLbN(rLbN), .rAddr(rAddr),
    .lStb(lStb), .rStb(rStb), .lIntN(lIntN), .rIntN(rIntN)
  );

  dpm_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_data (
    .clk(clk), .rstN(rstN),
    .lStb(lStb), .rStb(rStb), .lAddr(lAddr), .rAddr(rAddr),
    .lWrData(lWrData), .rWrData(rWrData),
    .lRdData(lRdData), .rRdData(rRdData),
    .lRdLaneOe(lRdLaneOe), .rRdLaneOe(rRdLaneOe)
  );
endmodule

// File: tb/test_dpm_top.sv
module test_dpm_top;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam logic [AW-1:0] RBOX = 8'd255;
  localparam logic [AW-1:0] LBOX = 8'd254;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lCe0N, lCe1N, lWeN, lOeN, lUbN, lLbN;
  logic rCe0N, rCe1N, rWeN, rOeN, rUbN, rLbN;
  logic [AW-1:0] lAddr, rAddr;
  logic [DW-1:0] lWrData, rWrData, lRdData, rRdData;
  logic [1:0] lRdLaneOe, rRdLaneOe;
  logic lIntN, rIntN;
  int nChk = 0;
  int nBad = 0;

  always #2 clk = ~clk;

  dpm_top #(.ADDR_W(AW), .DATA_W(DW)) i_dpm_top (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    {lCe0N, lCe1N, lWeN, lOeN, lUbN, lLbN} = 6'b101111;
    {rCe0N, rCe1N, rWeN, rOeN, rUbN, rLbN} = 6'b101111;
    lAddr = '0; rAddr = '0; lWrData = '0; rWrData = '0;
  endtask

  // side 0 = left, 1 = right; lanes bit0 lower, bit1 upper
  task automatic wr(bit side, logic [AW-1:0] a, logic [DW-1:0] d, logic [1:0] lanes);
    if (!side) begin
      {lCe0N, lCe1N, lWeN, lOeN} = 4'b0101; {lUbN, lLbN} = ~lanes; lAddr = a; lWrData = d;
    end else begin
      {rCe0N, rCe1N, rWeN, rOeN} = 4'b0101; {rUbN, rLbN} = ~lanes; rAddr = a; rWrData = d;
    end
  endtask

  task automatic rd(bit side, logic [AW-1:0] a, logic [1:0] lanes);
    if (!side) begin
      {lCe0N, lCe1N, lWeN, lOeN} = 4'b0110; {lUbN, lLbN} = ~lanes; lAddr = a;
    end else begin
      {rCe0N, rCe1N, rWeN, rOeN} = 4'b0110; {rUbN, rLbN} = ~lanes; rAddr = a;
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic stepIdle();
    @(negedge clk);
    idle();
  endtask

  task automatic tReset();
    chk("R10 lIntN", lIntN, 1);
    chk("R10 rIntN", rIntN, 1);
    chk("R10 lRdLaneOe", lRdLaneOe, 0);
    chk("R10 rRdData", rRdData, 0);
  endtask

  task automatic tBasic();
    wr(0, 8'd5, 16'hA5A5, 2'b11); stepIdle();
    rd(1, 8'd5, 2'b11); step();
    chk("R4 cross read", rRdData, 16'hA5A5);
    chk("R3 lane oe", rRdLaneOe, 2'b11);
    idle(); step();
    chk("R3 no read no drive", rRdLaneOe, 2'b00);
  endtask

  task automatic tLanes();
    wr(1, 8'd6, 16'h1234, 2'b11); stepIdle();
    wr(0, 8'd6, 16'hABCD, 2'b01); stepIdle();
    rd(0, 8'd6, 2'b11); step();
    chk("R2 lower lane write", lRdData, 16'h12CD);
    wr(0, 8'd6, 16'h9900, 2'b10); stepIdle();
    rd(1, 8'd6, 2'b10); step();
    chk("R3 upper only data", rRdData, 16'h9900);
    chk("R3 upper only oe", rRdLaneOe, 2'b10);
    idle();
  endtask

  task automatic tSelect();
    wr(0, 8'd5, 16'hFFFF, 2'b11); lCe1N = 1'b0; stepIdle();
    wr(1, 8'd5, 16'hEEEE, 2'b11); rCe0N = 1'b1; stepIdle();
    rd(0, 8'd5, 2'b11); lCe0N = 1'b1; step();
    chk("R1 ce0 high no drive", lRdLaneOe, 2'b00);
    chk("R1 ce0 high data zero", lRdData, 0);
    rd(0, 8'd5, 2'b11); lOeN = 1'b1; step();
    chk("R3 oe high no drive", lRdLaneOe, 2'b00);
    rd(0, 8'd5, 2'b11); step();
    chk("R1 deselected writes dropped", lRdData, 16'hA5A5);
    idle();
    wr(0, RBOX, 16'h0F0F, 2'b11); lCe1N = 1'b0; stepIdle();
    chk("R1 deselected mailbox write no flag", rIntN, 1);
  endtask

  task automatic tMailbox();
    wr(0, RBOX, 16'h55AA, 2'b11); stepIdle();
    chk("R5 right flag raised", rIntN, 0);
    chk("R5 left flag untouched", lIntN, 1);
    wr(0, LBOX, 16'h1111, 2'b11); stepIdle();
    chk("R6 own mailbox write no flag", lIntN, 1);
    rd(1, RBOX, 2'b11); step();
    chk("R11 right mailbox data", rRdData, 16'h55AA);
    chk("R6 right flag cleared", rIntN, 1);
    idle();
    wr(1, LBOX, 16'h2222, 2'b11); stepIdle();
    chk("R5 left flag raised", lIntN, 0);
    rd(0, LBOX, 2'b01); step();
    chk("R11 left mailbox data", lRdData, 16'h0022);
    chk("R6 left flag cleared", lIntN, 1);
    idle();
  endtask

  task automatic tSetWins();
    wr(1, LBOX, 16'h3333, 2'b11); stepIdle();
    rd(0, LBOX, 2'b11); wr(1, LBOX, 16'h4444, 2'b11); step();
    chk("R7 set beats clear", lIntN, 0);
    chk("R9 mailbox old data", lRdData, 16'h3333);
    rd(0, LBOX, 2'b11); rCe0N = 1'b1; step();
    chk("R11 new mailbox data", lRdData, 16'h4444);
    chk("R6 cleared after set", lIntN, 1);
    idle();
  endtask

  task automatic tCollide();
    wr(0, 8'd9, 16'hAAAA, 2'b11); wr(1, 8'd9, 16'h5555, 2'b11); stepIdle();
    rd(1, 8'd9, 2'b11); step();
    chk("R8 left wins full", rRdData, 16'hAAAA);
    idle();
    wr(0, 8'd9, 16'h00CC, 2'b01); wr(1, 8'd9, 16'h7777, 2'b11); stepIdle();
    rd(0, 8'd9, 2'b11); step();
    chk("R8 left wins partial", lRdData, 16'h77CC);
    idle();
  endtask

  task automatic tReadDuringWrite();
    rd(0, 8'd9, 2'b11); wr(1, 8'd9, 16'h0BAD, 2'b11); step();
    chk("R9 old data", lRdData, 16'h77CC);
    rd(0, 8'd9, 2'b11); rCe0N = 1'b1; step();
    chk("R9 then new data", lRdData, 16'h0BAD);
    idle();
  endtask

  initial begin
    fork
      begin
        idle();
        repeat (3) @(negedge clk);
        tReset();
        rstN = 1'b1;
        step();
        tBasic();
        tLanes();
        tSelect();
        tMailbox();
        tSetWins();
        tCollide();
        tReadDuringWrite();
      end
      begin
        repeat (5000) @(posedge clk);
        nChk++; nBad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule